// File: doc/BRIEF.md
# Colour Lookup RAM Host Port Sequencer

This block is the processor side of a colour lookup memory that holds 256 entries of 24 bits each. The host sees a byte-wide register port with two address views and one data view. A colour travels as three bytes, always red first, then green, then blue. Writes are gathered into a staging area and reach the memory only when the blue byte arrives. Reads are served from a 24-bit holding register that is filled ahead of time, both when a start location is loaded and again after every blue byte is read. After each complete triplet the address advances on its own, so a block of consecutive entries can be written or read as one stream of bytes.

The host uses a two-bit select. Value 00 loads the address for writing, 11 loads the address for a read that first fetches the entry, 01 is the colour data byte, and 10 is reserved. Reading either address view returns the current address. A narrow-mode input makes colour reads return six significant bits. A single sequencer drives the memory. Its states are IDLE (accepts host accesses), COMMIT (writes the staged word and advances the address), FETCH (presents the address to the memory) and LOAD (captures the entry into the holding register and advances the address). Its transitions are: IDLE to COMMIT on the blue data write; IDLE to FETCH on a read-view address load or on the blue data read; FETCH to LOAD always; COMMIT and LOAD back to IDLE always. Host strobes are accepted only in IDLE. The host leaves at least three clock cycles between accesses.

Top module: `palette_host_seq`

## Requirements
- R1: After reset the address is 0, the component pointer is at red, and a data read returns 0 in both modes.
- R2: A write with select 00 or 11 loads the address from the write data and returns the component pointer to red.
- R3: Three data writes (select 01) give red, green and blue. Only after the blue write is the word {red in bits 23:16, green in 15:8, blue in 7:0} stored at the current address.
- R4: After each stored word the address increases by one, so repeated triplets fill consecutive entries.
- R5: A write with select 11 copies the entry at the loaded address into the holding register and then increases the address by one.
- R6: Data reads (select 01) return red, green, then blue of the holding register. After the blue read, the entry at the current address is copied into the holding register and the address increases by one.
- R7: With narrow_mode high, each data read returns bits 7:2 of the component in bits 5:0, with bits 7:6 zero. With narrow_mode low, it returns all 8 bits.
- R8: The address wraps from 255 to 0 when it advances.
- R9: A partial triplet cut short by an address write leaves the memory unchanged.
- R10: A read of select 00 or 11 returns the current address, and a read of select 10 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 00 address for writing, 01 colour data, 10 reserved, 11 address with fetch |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe; advances the pointer on data reads |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte for the selected view |
| narrow_mode | input | 1 | High selects 6-bit colour readback |

## Verification
The hardest case to reach is a write triplet abandoned part-way, because nothing at the port shows the staged bytes or the component pointer. The stimulus first stores a known word. It then starts a new triplet at the same entry, sends only red and green, and reloads the address somewhere else. It then reads the first entry back and completes a fresh triplet at the new address, which shows both that the memory kept its old word and that the pointer went back to red. Address wrap is reached by loading 255 and writing two triplets, then reading across the boundary so that the refetch after the blue byte comes from entry 0.

// File: rtl/palette_host_pkg.sv
package palette_host_pkg;

    localparam int ADDR_W   = 8;
    localparam int COMP_W   = 8;
    localparam int NARROW_W = 6;
    localparam int WORD_W   = 3 * COMP_W;

    typedef enum logic [1:0] {
        SEL_ADDR_WR = 2'b00,
        SEL_DATA    = 2'b01,
        SEL_RSVD    = 2'b10,
        SEL_ADDR_RD = 2'b11
    } host_sel_t;

    typedef enum logic [1:0] {
        CMP_RED = 2'd0,
        CMP_GRN = 2'd1,
        CMP_BLU = 2'd2
    } comp_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COMMIT,
        ST_FETCH,
        ST_LOAD
    } seq_state_t;

endpackage

// File: rtl/palette_ram.sv
module palette_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/palette_read_fmt.sv
module palette_read_fmt #(
    parameter int CW = 8,
    parameter int NW = 6
) (
    input  logic [3*CW-1:0] hold,
    input  logic [1:0]      ptr,
    input  logic            narrow,
    output logic [CW-1:0]   byte_out
);
    import palette_host_pkg::*;

    logic [CW-1:0] comp;
    logic [CW-1:0] comp_narrow;

    always_comb begin
        unique case (ptr)
            CMP_RED: comp = hold[3*CW-1:2*CW];
            CMP_GRN: comp = hold[2*CW-1:CW];
            default: comp = hold[CW-1:0];
        endcase
    end

    generate
        if (NW < CW) begin : g_shift
            assign comp_narrow = {{(CW-NW){1'b0}}, comp[CW-1:CW-NW]};
        end else begin : g_same
            assign comp_narrow = comp;
        end
    endgenerate

    assign byte_out = narrow ? comp_narrow : comp;
endmodule

// File: rtl/palette_seq_ctrl.sv
module palette_seq_ctrl #(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      sel,
    input  logic            acc_wr,
    input  logic            acc_rd,
    input  logic [CW-1:0]   wdata,
    input  logic [3*CW-1:0] ram_q,
    output logic [AW-1:0]   addr,
    output logic [1:0]      ptr,
    output logic [3*CW-1:0] hold,
    output logic            ram_we,
    output logic [3*CW-1:0] ram_wdata,
    output logic            ram_re
);
    import palette_host_pkg::*;

    seq_state_t st, st_nxt;
    logic [CW-1:0] stg_r, stg_g, stg_b;
    logic          wr_fire, rd_fire, addr_load, data_wr, data_rd;

    assign wr_fire   = acc_wr && (st == ST_IDLE);
    assign rd_fire   = acc_rd && !acc_wr && (st == ST_IDLE);
    assign addr_load = wr_fire && (sel == SEL_ADDR_WR || sel == SEL_ADDR_RD);
    assign data_wr   = wr_fire && (sel == SEL_DATA);
    assign data_rd   = rd_fire && (sel == SEL_DATA);

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (wr_fire && sel == SEL_ADDR_RD)      st_nxt = ST_FETCH;
                else if (data_wr && ptr == CMP_BLU)     st_nxt = ST_COMMIT;
                else if (data_rd && ptr == CMP_BLU)     st_nxt = ST_FETCH;
            end
            ST_COMMIT: st_nxt = ST_IDLE;
            ST_FETCH:  st_nxt = ST_LOAD;
            ST_LOAD:   st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            ptr   <= CMP_RED;
            hold  <= '0;
            stg_r <= '0;
            stg_g <= '0;
            stg_b <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (addr_load) begin
                        addr <= wdata[AW-1:0];
                        ptr  <= CMP_RED;
                    end else if (data_wr) begin
                        unique case (ptr)
                            CMP_RED: begin stg_r <= wdata; ptr <= CMP_GRN; end
                            CMP_GRN: begin stg_g <= wdata; ptr <= CMP_BLU; end
                            default: begin stg_b <= wdata; ptr <= CMP_RED; end
                        endcase
                    end else if (data_rd) begin
                        unique case (ptr)
                            CMP_RED: ptr <= CMP_GRN;
                            CMP_GRN: ptr <= CMP_BLU;
                            default: ptr <= CMP_RED;
                        endcase
                    end
                end
                ST_COMMIT: addr <= addr + 1'b1;
                ST_FETCH:  ;
                ST_LOAD: begin
                    hold <= ram_q;
                    addr <= addr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ram_we    = (st == ST_COMMIT);
    assign ram_re    = (st == ST_FETCH);
    assign ram_wdata = {stg_r, stg_g, stg_b};

    p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (addr == $past(wdata[AW-1:0]) && ptr == CMP_RED));

    p_commit_after_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT) |-> ($past(data_wr) && ptr == CMP_RED));

    p_commit_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT) |=> (addr == $past(addr) + 1'b1));

    p_fetch_then_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (st == ST_LOAD && $stable(addr)));

    p_load_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOAD) |=> (hold == $past(ram_q) && st == ST_IDLE));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_COMMIT || st == ST_LOAD) && addr == {AW{1'b1}}) |=> (addr == '0));
endmodule

// File: rtl/palette_host_seq.sv
module palette_host_seq #(
    parameter int ADDR_W   = palette_host_pkg::ADDR_W,
    parameter int COMP_W   = palette_host_pkg::COMP_W,
    parameter int NARROW_W = palette_host_pkg::NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [COMP_W-1:0] host_wdata,
    output logic [COMP_W-1:0] host_rdata,
    input  logic              narrow_mode
);
    import palette_host_pkg::*;

    localparam int WW = 3 * COMP_W;

    logic [ADDR_W-1:0] addr;
    logic [1:0]        ptr;
    logic [WW-1:0]     hold, ram_q, ram_wdata;
    logic              ram_we, ram_re;
    logic [COMP_W-1:0] data_byte;
    logic [COMP_W-1:0] addr_byte;

    palette_seq_ctrl #(.AW(ADDR_W), .CW(COMP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (host_sel),
        .acc_wr    (host_wr),
        .acc_rd    (host_rd),
        .wdata     (host_wdata),
        .ram_q     (ram_q),
        .addr      (addr),
        .ptr       (ptr),
        .hold      (hold),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_re    (ram_re)
    );

    palette_ram #(.AW(ADDR_W), .DW(WW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (addr),
        .wdata (ram_wdata),
        .re    (ram_re),
        .raddr (addr),
        .rdata (ram_q)
    );

    palette_read_fmt #(.CW(COMP_W), .NW(NARROW_W)) u_fmt (
        .hold     (hold),
        .ptr      (ptr),
        .narrow   (narrow_mode),
        .byte_out (data_byte)
    );

    generate
        if (COMP_W >= ADDR_W) begin : g_addr_pad
            assign addr_byte = COMP_W'(addr);
        end else begin : g_addr_cut
            assign addr_byte = addr[COMP_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (host_sel)
            SEL_ADDR_WR, SEL_ADDR_RD: host_rdata = addr_byte;
            SEL_DATA:                 host_rdata = data_byte;
            default:                  host_rdata = '0;
        endcase
    end

    p_ram_we_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(host_wr && host_sel == SEL_DATA));

    p_narrow_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_mode && host_sel == SEL_DATA) |-> (host_rdata[COMP_W-1:NARROW_W] == '0));
endmodule

// File: tb/palette_host_seq_test.sv
module palette_host_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'b00;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       narrow_mode = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_mem [256];
    int m_addr = 0;
    int m_ptr = 0;
    int m_stage [3];
    int m_hold = 0;

    always #10 clk = ~clk;

    palette_host_seq uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .narrow_mode(narrow_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gap();
        repeat (3) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] sel, input int d);
        @(negedge clk);
        host_sel = sel; host_wdata = 8'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (sel == 2'b00 || sel == 2'b11) begin
            m_addr = d; m_ptr = 0;
            if (sel == 2'b11) begin
                m_hold = m_mem[m_addr]; m_addr = (m_addr + 1) % 256;
            end
        end else if (sel == 2'b01) begin
            m_stage[m_ptr] = d;
            if (m_ptr == 2) begin
                m_mem[m_addr] = (m_stage[0] << 16) | (m_stage[1] << 8) | m_stage[2];
                m_addr = (m_addr + 1) % 256; m_ptr = 0;
            end else m_ptr++;
        end
        gap();
    endtask

    function automatic int exp_byte(int hold, int ptr, bit narrow);
        int c;
        c = (hold >> (8 * (2 - ptr))) & 8'hff;
        return narrow ? (c >> 2) : c;
    endfunction

    task automatic host_read_data(input string req);
        @(negedge clk);
        host_sel = 2'b01; host_rd = 1'b1;
        #1;
        check(req, int'(host_rdata), exp_byte(m_hold, m_ptr, narrow_mode));
        @(negedge clk);
        host_rd = 1'b0;
        if (m_ptr == 2) begin
            m_hold = m_mem[m_addr]; m_addr = (m_addr + 1) % 256; m_ptr = 0;
        end else m_ptr++;
        gap();
    endtask

    task automatic check_addr(input string req);
        @(negedge clk);
        host_sel = 2'b00; #1;
        check(req, int'(host_rdata), m_addr);
        host_sel = 2'b11; #1;
        check(req, int'(host_rdata), m_addr);
    endtask

    task automatic triplet(input int r, input int g, input int b);
        host_write(2'b01, r); host_write(2'b01, g); host_write(2'b01, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_addr("R1");
        host_sel = 2'b01; #1;
        check("R1", int'(host_rdata), 0);
        narrow_mode = 1'b1; #1;
        check("R1", int'(host_rdata), 0);
        narrow_mode = 1'b0;
        // R10: reserved view reads zero
        host_sel = 2'b10; #1;
        check("R10", int'(host_rdata), 0);

        // R2 R3 R4: block write of three entries from 10
        host_write(2'b00, 10);
        check_addr("R2");
        triplet(8'hA1, 8'hB2, 8'hC3);
        triplet(8'h14, 8'h25, 8'h36);
        triplet(8'hFF, 8'h80, 8'h7F);
        check_addr("R4");

        // R5 R6: block read from 10
        host_write(2'b11, 10);
        check_addr("R5");
        for (int i = 0; i < 9; i++) host_read_data("R6");
        check_addr("R6");

        // R7: narrow readback of entry 12
        narrow_mode = 1'b1;
        host_write(2'b11, 12);
        for (int i = 0; i < 3; i++) host_read_data("R7");
        narrow_mode = 1'b0;

        // R9: abandoned triplet at 11, then fresh triplet at 20
        host_write(2'b00, 11);
        host_write(2'b01, 8'h01);
        host_write(2'b01, 8'h02);
        host_write(2'b00, 20);
        check_addr("R9");
        triplet(8'h5A, 8'h6B, 8'h7C);
        host_write(2'b11, 11);
        for (int i = 0; i < 3; i++) host_read_data("R9");
        host_write(2'b11, 20);
        for (int i = 0; i < 3; i++) host_read_data("R9");

        // R8: wrap on write and on read refetch
        host_write(2'b00, 255);
        triplet(8'h11, 8'h22, 8'h33);
        check_addr("R8");
        triplet(8'h44, 8'h55, 8'h66);
        check_addr("R8");
        host_write(2'b11, 255);
        check_addr("R8");
        for (int i = 0; i < 6; i++) host_read_data("R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule